// File: doc/BRIEF.md
# Serial Card Command Port Interpreter

This block sits behind a small byte-wide host I/O window of a serial expansion card. The host does not address configuration registers one by one. It writes a command code to a command port, then either writes the parameter bytes for that command to a parameter port, or reads the command's result bytes back through the same two offsets. The block decodes the command and counts the parameter bytes the command needs. When the last byte arrives, it updates the card's configuration: operating mode, flow-control type, and the receive-FIFO high and low thresholds.

The block answers two query commands: one returns the card's DIP-switch byte, the other returns self-test and firmware-revision status. Reads at the window base return a fixed signature, so a host probe can tell whether a card is fitted. A write to the command port always starts a fresh sequence. It drops any parameter bytes that were collected but not yet committed. Writes and reads use a single-cycle synchronous strobe. Read data is combinational from the registered state.

Top module: `cmdport_ctl`

## Requirements
- R1: After reset, every configuration output is 0, and reads at the command and parameter offsets return 0x00.
- R2: A read at offset 0 returns the signature 0x5A, which is nonzero under mask 0xF3.
- R3: A write to offset 4 loads a new command code and clears the parameter byte count. A partly written sequence is dropped without any effect.
- R4: Command 0x10 takes one parameter byte. In it, bit 1 sets `cfg_fifo_compat`, bit 2 sets `cfg_rts_hw` and bit 7 sets `cfg_trig_scale`.
- R5: Command 0x08 takes two parameter bytes. Bit 2 of the first byte sets `cfg_rx_rts`. Bit 4 of the second byte sets `cfg_tx_cts`.
- R6: Command 0x0A takes four parameter bytes: the high threshold, high byte first, then the low threshold, high byte first. They appear on `rx_hi_thr` and `rx_lo_thr`.
- R7: Configuration outputs change only in the cycle after the final parameter byte of a command is written. Earlier bytes leave the outputs unchanged.
- R8: Parameter writes beyond the count for the current command are ignored. So are parameter writes after a command code that takes no parameters or is unknown.
- R9: After command 0x02, a read at offset 4 returns the live `dip_sw` byte. Bits 1:0 of that byte are the legacy base index, and bit 7 is the 16550-capable flag.
- R10: After command 0x01, a read at offset 4 returns 0x00. A read at offset 5 returns the firmware revision in bits 6:4 with all other bits 0, which is 0x20 for revision 2.
- R11: Reads at offsets 1, 2, 3, 6 and 7 return 0x00. A read at offset 4 or 5 after any other command also returns 0x00, and so does any cycle with `host_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Byte offset within the I/O window |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational |
| dip_sw | input | 8 | On-board switch byte |
| cfg_fifo_compat | output | 1 | 16550-compatible FIFO mode |
| cfg_rts_hw | output | 1 | RTS hardware flow control enabled |
| cfg_trig_scale | output | 1 | FIFO trigger levels scaled |
| cfg_rx_rts | output | 1 | Receiver drives RTS |
| cfg_tx_cts | output | 1 | Transmitter obeys CTS |
| rx_hi_thr | output | 16 | Receive flow high threshold |
| rx_lo_thr | output | 16 | Receive flow low threshold |

## Verification
The hardest case to reach from the ports is an interrupted sequence. In it, a multi-byte threshold command has taken some of its bytes when a new command code arrives. The stale bytes still sit in the shift buffer, so a correct design must neither commit them nor let them mix with the new command's bytes. The bench writes two of the four threshold bytes, then issues a mode command. It checks that the mode changed and the thresholds did not. It then runs a fresh four-byte sequence whose values differ from the abandoned bytes. Surplus parameter bytes after a commit, and bytes sent after an unknown code, are checked the same way, by watching that every configuration output holds.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 3;

  typedef enum logic [7:0] {
    CMD_SELFTEST = 8'h01,
    CMD_DIPS     = 8'h02,
    CMD_FLOWTYPE = 8'h08,
    CMD_RXLEVELS = 8'h0A,
    CMD_MODE     = 8'h10
  } cmd_code_e;

  // Number of parameter bytes a command consumes through the parameter port.
  function automatic logic [CNT_W-1:0] param_count(input logic [BYTE_W-1:0] code);
    case (code)
      CMD_MODE:     return 3'd1;
      CMD_FLOWTYPE: return 3'd2;
      CMD_RXLEVELS: return 3'd4;
      default:      return 3'd0;
    endcase
  endfunction

  // Status byte carrying the firmware revision in bits 6:4.
  function automatic logic [BYTE_W-1:0] rev_status(input logic [2:0] rev);
    return {1'b0, rev, 4'b0000};
  endfunction

endpackage

// File: rtl/cmdport_decode.sv
module cmdport_decode #(
  parameter int ADDR_W  = 3,
  parameter int CMD_OFS = 4,
  parameter int PRM_OFS = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              cmd_wr,
  output logic              prm_wr
);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] PRM_A = ADDR_W'(PRM_OFS);

  always_comb begin
    cmd_wr = wr && (addr == CMD_A);
    prm_wr = wr && (addr == PRM_A);
  end
endmodule

// File: rtl/cmdport_seq.sv
module cmdport_seq
  import cmdport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              prm_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cur_cmd,
  output logic              commit,
  output logic [4*BYTE_W-1:0] commit_word
);
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    need;
  logic [3*BYTE_W-1:0] pbuf;
  logic                prm_accept;

  always_comb begin
    need        = param_count(cur_cmd);
    prm_accept  = prm_wr && (cnt < need);
    commit      = prm_accept && (cnt == need - 3'd1);
    commit_word = {pbuf, wdata};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_cmd <= '0;
      cnt     <= '0;
      pbuf    <= '0;
    end else if (cmd_wr) begin
      cur_cmd <= wdata;
      cnt     <= '0;
    end else if (prm_accept) begin
      cnt  <= cnt + 3'd1;
      pbuf <= {pbuf[2*BYTE_W-1:0], wdata};
    end
  end

  AST_CMD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cnt == '0)); // R3
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= need); // R8
  AST_COMMIT_ON_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> prm_wr); // R7
endmodule

// File: rtl/cmdport_regs.sv
module cmdport_regs
  import cmdport_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int SIG_OFS   = 0,
  parameter int CMD_OFS   = 4,
  parameter int PRM_OFS   = 5,
  parameter int THR_W     = 16,
  parameter logic [7:0] SIGNATURE = 8'h5A,
  parameter logic [2:0] FW_REV    = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [BYTE_W-1:0] cur_cmd,
  input  logic [4*BYTE_W-1:0] commit_word,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] dip_sw,
  output logic [BYTE_W-1:0] rdata,
  output logic              cfg_fifo_compat,
  output logic              cfg_rts_hw,
  output logic              cfg_trig_scale,
  output logic              cfg_rx_rts,
  output logic              cfg_tx_cts,
  output logic [THR_W-1:0]  rx_hi_thr,
  output logic [THR_W-1:0]  rx_lo_thr
);
  localparam logic [ADDR_W-1:0] SIG_A = ADDR_W'(SIG_OFS);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] PRM_A = ADDR_W'(PRM_OFS);

  logic commit_mode, commit_flow, commit_lvls;
  logic [BYTE_W-1:0] b_last, b_prev;

  always_comb begin
    commit_mode = commit && (cur_cmd == CMD_MODE);
    commit_flow = commit && (cur_cmd == CMD_FLOWTYPE);
    commit_lvls = commit && (cur_cmd == CMD_RXLEVELS);
    b_last      = commit_word[BYTE_W-1:0];
    b_prev      = commit_word[2*BYTE_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_fifo_compat <= 1'b0;
      cfg_rts_hw      <= 1'b0;
      cfg_trig_scale  <= 1'b0;
      cfg_rx_rts      <= 1'b0;
      cfg_tx_cts      <= 1'b0;
      rx_hi_thr       <= '0;
      rx_lo_thr       <= '0;
    end else begin
      if (commit_mode) begin
        cfg_fifo_compat <= b_last[1];
        cfg_rts_hw      <= b_last[2];
        cfg_trig_scale  <= b_last[7];
      end
      if (commit_flow) begin
        cfg_rx_rts <= b_prev[2];
        cfg_tx_cts <= b_last[4];
      end
      if (commit_lvls) begin
        rx_hi_thr <= THR_W'(commit_word[4*BYTE_W-1:2*BYTE_W]);
        rx_lo_thr <= THR_W'(commit_word[2*BYTE_W-1:0]);
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == SIG_A)
        rdata = SIGNATURE;
      else if (addr == CMD_A && cur_cmd == CMD_DIPS)
        rdata = dip_sw;
      else if (addr == PRM_A && cur_cmd == CMD_SELFTEST)
        rdata = rev_status(FW_REV);
    end
  end

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(rx_hi_thr) && $stable(rx_lo_thr))); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(cfg_fifo_compat) && $stable(cfg_rts_hw) && $stable(cfg_trig_scale))); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0)); // R11
endmodule

// File: rtl/cmdport_ctl.sv
module cmdport_ctl
  import cmdport_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int SIG_OFS   = 0,
  parameter int CMD_OFS   = 4,
  parameter int PRM_OFS   = 5,
  parameter int THR_W     = 16,
  parameter logic [7:0] SIGNATURE = 8'h5A,
  parameter logic [2:0] FW_REV    = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [7:0]        dip_sw,
  output logic              cfg_fifo_compat,
  output logic              cfg_rts_hw,
  output logic              cfg_trig_scale,
  output logic              cfg_rx_rts,
  output logic              cfg_tx_cts,
  output logic [THR_W-1:0]  rx_hi_thr,
  output logic [THR_W-1:0]  rx_lo_thr
);
  logic              cmd_wr, prm_wr, commit;
  logic [BYTE_W-1:0] cur_cmd;
  logic [4*BYTE_W-1:0] commit_word;

  cmdport_decode #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .PRM_OFS(PRM_OFS)) u_dec (
    .addr(host_addr), .wr(host_wr), .cmd_wr(cmd_wr), .prm_wr(prm_wr));

  cmdport_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .prm_wr(prm_wr),
    .wdata(host_wdata), .cur_cmd(cur_cmd), .commit(commit),
    .commit_word(commit_word));

  cmdport_regs #(
    .ADDR_W(ADDR_W), .SIG_OFS(SIG_OFS), .CMD_OFS(CMD_OFS), .PRM_OFS(PRM_OFS),
    .THR_W(THR_W), .SIGNATURE(SIGNATURE), .FW_REV(FW_REV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cur_cmd(cur_cmd),
    .commit_word(commit_word), .addr(host_addr), .rd(host_rd), .dip_sw(dip_sw),
    .rdata(host_rdata), .cfg_fifo_compat(cfg_fifo_compat), .cfg_rts_hw(cfg_rts_hw),
    .cfg_trig_scale(cfg_trig_scale), .cfg_rx_rts(cfg_rx_rts), .cfg_tx_cts(cfg_tx_cts),
    .rx_hi_thr(rx_hi_thr), .rx_lo_thr(rx_lo_thr));

  AST_SIG_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(SIG_OFS)) |-> ((host_rdata & 8'hF3) != 8'h00)); // R2
  AST_CMD_WRITE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> !commit); // R3
endmodule

// File: tb/cmdport_ctl_test.sv
`timescale 1ns/1ps
module cmdport_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, dip_sw = '0;
  logic [7:0] host_rdata;
  logic cfg_fifo_compat, cfg_rts_hw, cfg_trig_scale, cfg_rx_rts, cfg_tx_cts;
  logic [15:0] rx_hi_thr, rx_lo_thr;

  int checks = 0, errors = 0;
  logic e_fifo = 0, e_rts = 0, e_scale = 0, e_rxrts = 0, e_txcts = 0;
  logic [15:0] e_hi = 0, e_lo = 0;

  always #2.5 clk = ~clk;

  cmdport_ctl uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic cfg_all(input string tag);
    logic [31:0] act, exp;
    act = {cfg_fifo_compat, cfg_rts_hw, cfg_trig_scale, cfg_rx_rts, cfg_tx_cts};
    exp = {e_fifo, e_rts, e_scale, e_rxrts, e_txcts};
    chk(act == exp, {tag, " flags"}, act, exp);
    chk(rx_hi_thr == e_hi, {tag, " hi"}, rx_hi_thr, e_hi);
    chk(rx_lo_thr == e_lo, {tag, " lo"}, rx_lo_thr, e_lo);
  endtask

  task automatic levels(input logic [15:0] hi, input logic [15:0] lo);
    wr(3'd4, 8'h0A);
    wr(3'd5, hi[15:8]); wr(3'd5, hi[7:0]); wr(3'd5, lo[15:8]);
    cfg_all("R7 three of four level bytes");
    wr(3'd5, lo[7:0]);
    e_hi = hi; e_lo = lo;
    cfg_all("R6 levels");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cfg_all("R1 reset");
    rd(3'd4, r); chk(r == 8'h00, "R1 status1 after reset", r, 8'h00);
    rd(3'd5, r); chk(r == 8'h00, "R1 status2 after reset", r, 8'h00);
    // R2 signature
    rd(3'd0, r);
    chk(r == 8'h5A, "R2 signature", r, 8'h5A);
    chk((r & 8'hF3) != 0, "R2 signature mask", r & 8'hF3, 32'h1);
    // R11 idle read and unused offsets
    @(negedge clk); host_addr = 3'd0; #1;
    chk(host_rdata == 8'h00, "R11 no read strobe", host_rdata, 8'h00);
    for (int a = 1; a < 8; a++) begin
      if (a == 4 || a == 5) continue;
      rd(3'(a), r); chk(r == 8'h00, "R11 unused offset", r, 8'h00);
    end
    // R4 exhaustive mode byte
    for (int m = 0; m < 256; m++) begin
      wr(3'd4, 8'h10); wr(3'd5, 8'(m));
      e_fifo = m[1]; e_rts = m[2]; e_scale = m[7];
      cfg_all("R4 mode");
    end
    // R5 flow type sweep, with R7 check after first byte
    for (int v = 0; v < 256; v++) begin
      wr(3'd4, 8'h08); wr(3'd5, 8'(v));
      cfg_all("R7 first flow byte");
      wr(3'd5, ~8'(v));
      e_rxrts = v[2]; e_txcts = ~v[4];
      cfg_all("R5 flow type");
    end
    // R6 threshold values
    for (int i = 0; i < 32; i++)
      levels(16'(i * 2053 + 768), 16'(i * 977 + 512));
    // R8 extra bytes after commit
    wr(3'd5, 8'hFF); wr(3'd5, 8'h00);
    cfg_all("R8 surplus level bytes");
    wr(3'd4, 8'h10); wr(3'd5, 8'h00); e_fifo = 0; e_rts = 0; e_scale = 0;
    wr(3'd5, 8'hFF);
    cfg_all("R8 surplus mode byte");
    // R8 unknown command and zero-param command
    wr(3'd4, 8'h33);
    for (int k = 0; k < 6; k++) wr(3'd5, 8'hFF);
    cfg_all("R8 unknown command");
    wr(3'd4, 8'h02);
    for (int k = 0; k < 6; k++) wr(3'd5, 8'h86);
    cfg_all("R8 dip command params");
    // R3 abandoned sequence
    wr(3'd4, 8'h0A); wr(3'd5, 8'hAB); wr(3'd5, 8'hCD);
    wr(3'd4, 8'h10); wr(3'd5, 8'h86);
    e_fifo = 1; e_rts = 1; e_scale = 1;
    cfg_all("R3 abandon then mode");
    wr(3'd4, 8'h0A); wr(3'd5, 8'h12);
    wr(3'd4, 8'h0A);
    levels(16'h0300, 16'h0200);
    // R9 dip passthrough
    wr(3'd4, 8'h02);
    for (int d = 0; d < 256; d++) begin
      dip_sw = 8'(d);
      rd(3'd4, r); chk(r == 8'(d), "R9 dip byte", r, 8'(d));
    end
    rd(3'd5, r); chk(r == 8'h00, "R11 status2 after dip", r, 8'h00);
    // R10 self test
    wr(3'd4, 8'h01);
    rd(3'd4, r); chk(r == 8'h00, "R10 status1 self test", r, 8'h00);
    rd(3'd5, r); chk(r == 8'h20, "R10 status2 revision", r, 8'h20);
    chk(((r >> 4) & 8'h7) == 8'h2, "R10 revision field", (r >> 4) & 8'h7, 2);
    // R11 status after a config command
    wr(3'd4, 8'h10);
    rd(3'd4, r); chk(r == 8'h00, "R11 status1 after mode", r, 8'h00);
    rd(3'd5, r); chk(r == 8'h00, "R11 status2 after mode", r, 8'h00);
    cfg_all("R11 reads leave config");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule